// File: doc/BRIEF.md
# VLAN Membership Table Access Engine

This block holds one port-membership bitmask for every VLAN identifier of a switch and lets a host reach it only indirectly. The host first loads a VLAN identifier into an index register. It then writes an access register that carries a command code together with a port-mask field. The engine accepts the command only while it is idle. It runs the command over one or more clock cycles and then drops the command code back to idle. The host learns that the command has finished by polling for that idle code. A read leaves the stored mask in the port-mask field of the access register. A write stores the mask carried in the same access. A clear-all command walks every entry and zeroes it.

A second, independent lookup port serves the forwarding logic. It returns the member mask of any VLAN identifier one cycle after the request. When a lookup and a host write land on the same cycle, the lookup sees the old contents. When reset is released, the engine runs the same clearing sweep as a clear-all command, so the table starts with no members anywhere.

Top module: `vlan_member_table`

## Requirements
- R1: After reset the command field reads clear-all (3) for exactly 2^VID_W cycles, then idle (0). The port-mask field and the index register read 0, and every entry holds an empty mask.
- R2: The command field is 2 bits wide: 0 idle, 1 read, 2 write, 3 clear-all. Any code other than 0 means the engine is busy.
- R3: An access write with code 2, accepted while idle, stores the written mask into the entry selected by the index register. The command field reads 2 for one cycle and then reads 0.
- R4: An access write with code 1, accepted while idle, makes the command field read 1 for two cycles. In the following cycle the field reads 0 and the port-mask field holds the stored entry of the indexed VLAN.
- R5: An access write with code 3, accepted while idle, zeroes every entry. The command field reads 3 for exactly 2^VID_W cycles and then reads 0.
- R6: Any access write made while the command field is not 0 has no effect: the command field, the port-mask field and the table all stay unchanged.
- R7: The index register takes a new VLAN identifier on every index write and reads it back. A command uses the index value present when the command was accepted, even if the index is rewritten while the command runs. Entries other than the target are left unchanged.
- R8: An access write with code 0 while idle updates only the port-mask field and leaves the table unchanged.
- R9: A lookup request in cycle N gives lookup-valid high and the entry's mask in cycle N+1. Lookup-valid is low in a cycle that follows no request.
- R10: A lookup of the entry being written by a host write in the same cycle returns the value from before the write. A later lookup returns the new value.
- R11: A lookup requested while a clearing sweep runs returns an empty mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Index register write strobe |
| idx_wvid | input | VID_W | VLAN identifier to load into the index register |
| idx_vid | output | VID_W | Current index register contents |
| acc_we | input | 1 | Access register write strobe |
| acc_wcmd | input | 2 | Command code written to the access register |
| acc_wmask | input | NUM_PORTS | Port-mask field written to the access register |
| acc_cmd | output | 2 | Command field; returns to 0 when a command is done |
| acc_mask | output | NUM_PORTS | Port-mask field of the access register |
| lk_req | input | 1 | Lookup request |
| lk_vid | input | VID_W | VLAN identifier to look up |
| lk_valid | output | 1 | Lookup result valid, one cycle after the request |
| lk_mask | output | NUM_PORTS | Member mask returned by the lookup |

## Verification
The bench builds the block with NUM_PORTS = 10 and VID_W = 6. That gives a 64-entry table, so the reset sweep and the clear-all sweep each finish in 64 cycles. The bench can then count a full sweep exactly and still reach the first entry, the last entry and every entry in between during random traffic. The ten-bit mask matches the default, so every port bit, including the highest, is exercised by random masks and by the all-ones mask written during a sweep.

// File: rtl/vmt_pkg.sv
package vmt_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_CLEAR = 2'd3
    } vmt_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_ADDR = 3'd1,
        ST_RD_CAP  = 3'd2,
        ST_WR      = 3'd3,
        ST_SWEEP   = 3'd4
    } vmt_state_e;

    // Command code the host sees for each sequencer state
    function automatic vmt_cmd_e cmd_of_state(vmt_state_e s);
        vmt_cmd_e c;
        case (s)
            ST_RD_ADDR, ST_RD_CAP: c = CMD_READ;
            ST_WR:                 c = CMD_WRITE;
            ST_SWEEP:              c = CMD_CLEAR;
            default:               c = CMD_IDLE;
        endcase
        return c;
    endfunction

    function automatic logic state_writes(vmt_state_e s);
        return (s == ST_WR) || (s == ST_SWEEP);
    endfunction

endpackage

// File: rtl/vmt_store.sv
module vmt_store #(
    parameter int WIDTH = 10,
    parameter int AW    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             hrd_en,
    input  logic [AW-1:0]    hrd_addr,
    output logic [WIDTH-1:0] hrd_data,
    input  logic             lk_en,
    input  logic [AW-1:0]    lk_addr,
    output logic [WIDTH-1:0] lk_data
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];

    // One write port, two registered read ports; reads return pre-write data
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (hrd_en) begin
            hrd_data <= mem[hrd_addr];
        end
        if (lk_en) begin
            lk_data <= mem[lk_addr];
        end
    end

    AST_WR_ADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
        we |-> !$isunknown(waddr)); // R3

endmodule

// File: rtl/vmt_seq.sv
module vmt_seq
    import vmt_pkg::*;
#(
    parameter int NUM_PORTS = 10,
    parameter int VID_W     = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idx_we,
    input  logic [VID_W-1:0]     idx_wvid,
    input  logic                 acc_we,
    input  logic [1:0]           acc_wcmd,
    input  logic [NUM_PORTS-1:0] acc_wmask,
    input  logic [NUM_PORTS-1:0] hrd_data,
    output logic [VID_W-1:0]     idx_vid,
    output logic [1:0]           acc_cmd,
    output logic [NUM_PORTS-1:0] acc_mask,
    output logic                 mem_we,
    output logic [VID_W-1:0]     mem_waddr,
    output logic [NUM_PORTS-1:0] mem_wdata,
    output logic                 hrd_en,
    output logic [VID_W-1:0]     hrd_addr,
    output logic                 sweeping
);
    localparam logic [VID_W-1:0] LAST_VID = {VID_W{1'b1}};

    vmt_state_e           st_q, st_d;
    logic [VID_W-1:0]     idx_q;
    logic [VID_W-1:0]     op_vid_q;
    logic [VID_W-1:0]     ptr_q;
    logic [NUM_PORTS-1:0] mask_q;
    logic                 accept;
    vmt_cmd_e             req_cmd;

    assign req_cmd = vmt_cmd_e'(acc_wcmd);
    assign accept  = acc_we && (st_q == ST_IDLE);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    case (req_cmd)
                        CMD_READ:  st_d = ST_RD_ADDR;
                        CMD_WRITE: st_d = ST_WR;
                        CMD_CLEAR: st_d = ST_SWEEP;
                        default:   st_d = ST_IDLE;
                    endcase
                end
            end
            ST_RD_ADDR: st_d = ST_RD_CAP;
            ST_RD_CAP:  st_d = ST_IDLE;
            ST_WR:      st_d = ST_IDLE;
            ST_SWEEP:   st_d = (ptr_q == LAST_VID) ? ST_IDLE : ST_SWEEP;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_SWEEP;
            idx_q    <= '0;
            op_vid_q <= '0;
            ptr_q    <= '0;
            mask_q   <= '0;
        end else begin
            st_q <= st_d;
            if (idx_we) begin
                idx_q <= idx_wvid;
            end
            if (accept) begin
                mask_q   <= acc_wmask;
                op_vid_q <= idx_q;
                ptr_q    <= '0;
            end
            if (st_q == ST_RD_CAP) begin
                mask_q <= hrd_data;
            end
            if (st_q == ST_SWEEP) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign idx_vid   = idx_q;
    assign acc_cmd   = cmd_of_state(st_q);
    assign acc_mask  = mask_q;
    assign sweeping  = (st_q == ST_SWEEP);
    assign mem_we    = state_writes(st_q);
    assign mem_waddr = sweeping ? ptr_q : op_vid_q;
    assign mem_wdata = sweeping ? '0 : mask_q;
    assign hrd_en    = (st_q == ST_RD_ADDR);
    assign hrd_addr  = op_vid_q;

    AST_WRITE_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (acc_cmd == CMD_WRITE) |=> (acc_cmd == CMD_IDLE)); // R3

    AST_READ_SEQ: assert property (@(posedge clk) disable iff (rst)
        (acc_cmd == CMD_IDLE && acc_we && acc_wcmd == CMD_READ)
        |=> (acc_cmd == CMD_READ) ##1 (acc_cmd == CMD_READ) ##1 (acc_cmd == CMD_IDLE)); // R4

    AST_CLEAR_START: assert property (@(posedge clk) disable iff (rst)
        (acc_cmd == CMD_IDLE && acc_we && acc_wcmd == CMD_CLEAR)
        |=> (acc_cmd == CMD_CLEAR)); // R5

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (acc_cmd != CMD_IDLE && st_q != ST_RD_CAP && acc_we) |=> $stable(acc_mask)); // R6

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> (idx_vid == $past(idx_wvid))); // R7

endmodule

// File: rtl/vmt_lookup.sv
module vmt_lookup #(
    parameter int NUM_PORTS = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic                 sweep_i,
    input  logic [NUM_PORTS-1:0] raw_i,
    output logic                 valid_o,
    output logic [NUM_PORTS-1:0] mask_o
);
    logic valid_q;
    logic zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            valid_q <= req_i;
            zero_q  <= req_i && sweep_i;
        end
    end

    // A sweep logically empties the whole table at once
    assign valid_o = valid_q;
    assign mask_o  = zero_q ? '0 : raw_i;

    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o); // R9

    AST_LK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !valid_o); // R9

    AST_SWEEP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_i && sweep_i) |=> (mask_o == '0)); // R11

endmodule

// File: rtl/vlan_member_table.sv
module vlan_member_table
    import vmt_pkg::*;
#(
    parameter int NUM_PORTS = 10,
    parameter int VID_W     = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idx_we,
    input  logic [VID_W-1:0]     idx_wvid,
    output logic [VID_W-1:0]     idx_vid,
    input  logic                 acc_we,
    input  logic [1:0]           acc_wcmd,
    input  logic [NUM_PORTS-1:0] acc_wmask,
    output logic [1:0]           acc_cmd,
    output logic [NUM_PORTS-1:0] acc_mask,
    input  logic                 lk_req,
    input  logic [VID_W-1:0]     lk_vid,
    output logic                 lk_valid,
    output logic [NUM_PORTS-1:0] lk_mask
);
    logic                 mem_we;
    logic [VID_W-1:0]     mem_waddr;
    logic [NUM_PORTS-1:0] mem_wdata;
    logic                 hrd_en;
    logic [VID_W-1:0]     hrd_addr;
    logic [NUM_PORTS-1:0] hrd_data;
    logic [NUM_PORTS-1:0] lk_raw;
    logic                 sweeping;

    vmt_seq #(.NUM_PORTS(NUM_PORTS), .VID_W(VID_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .idx_we    (idx_we),
        .idx_wvid  (idx_wvid),
        .acc_we    (acc_we),
        .acc_wcmd  (acc_wcmd),
        .acc_wmask (acc_wmask),
        .hrd_data  (hrd_data),
        .idx_vid   (idx_vid),
        .acc_cmd   (acc_cmd),
        .acc_mask  (acc_mask),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .hrd_en    (hrd_en),
        .hrd_addr  (hrd_addr),
        .sweeping  (sweeping)
    );

    vmt_store #(.WIDTH(NUM_PORTS), .AW(VID_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wdata    (mem_wdata),
        .hrd_en   (hrd_en),
        .hrd_addr (hrd_addr),
        .hrd_data (hrd_data),
        .lk_en    (lk_req),
        .lk_addr  (lk_vid),
        .lk_data  (lk_raw)
    );

    vmt_lookup #(.NUM_PORTS(NUM_PORTS)) u_lookup (
        .clk     (clk),
        .rst     (rst),
        .req_i   (lk_req),
        .sweep_i (sweeping),
        .raw_i   (lk_raw),
        .valid_o (lk_valid),
        .mask_o  (lk_mask)
    );

    AST_RESET_SWEEP: assert property (@(posedge clk)
        $fell(rst) |-> (acc_cmd == CMD_CLEAR && acc_mask == '0)); // R1

    AST_CMD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (acc_cmd == CMD_READ) |=> (acc_cmd == CMD_READ || acc_cmd == CMD_IDLE)); // R2

endmodule

// File: tb/tb_vlan_member_table.sv
`timescale 1ns/1ps
module tb_vlan_member_table;
    localparam int NP    = 10;
    localparam int VW    = 6;
    localparam int DEPTH = 1 << VW;

    logic          clk = 1'b0;
    logic          rst;
    logic          idx_we;
    logic [VW-1:0] idx_wvid;
    logic [VW-1:0] idx_vid;
    logic          acc_we;
    logic [1:0]    acc_wcmd;
    logic [NP-1:0] acc_wmask;
    logic [1:0]    acc_cmd;
    logic [NP-1:0] acc_mask;
    logic          lk_req;
    logic [VW-1:0] lk_vid;
    logic          lk_valid;
    logic [NP-1:0] lk_mask;

    vlan_member_table #(.NUM_PORTS(NP), .VID_W(VW)) dut (
        .clk(clk), .rst(rst),
        .idx_we(idx_we), .idx_wvid(idx_wvid), .idx_vid(idx_vid),
        .acc_we(acc_we), .acc_wcmd(acc_wcmd), .acc_wmask(acc_wmask),
        .acc_cmd(acc_cmd), .acc_mask(acc_mask),
        .lk_req(lk_req), .lk_vid(lk_vid), .lk_valid(lk_valid), .lk_mask(lk_mask)
    );

    always #4 clk = ~clk;

    logic [NP-1:0] model [DEPTH];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_idx(int v);
        idx_we = 1'b1; idx_wvid = VW'(v);
        cyc();
        idx_we = 1'b0;
    endtask

    task automatic issue(logic [1:0] c, logic [NP-1:0] m);
        acc_we = 1'b1; acc_wcmd = c; acc_wmask = m;
        cyc();
        acc_we = 1'b0;
    endtask

    task automatic do_write(int v, logic [NP-1:0] m);
        set_idx(v);
        issue(2'd2, m);
        chk("R3 write busy", 32'(acc_cmd), 32'd2);
        cyc();
        chk("R3 write done", 32'(acc_cmd), 32'd0);
        model[v] = m;
    endtask

    task automatic do_read(int v);
        set_idx(v);
        issue(2'd1, '0);
        chk("R4 read busy1", 32'(acc_cmd), 32'd1);
        cyc();
        chk("R4 read busy2", 32'(acc_cmd), 32'd1);
        cyc();
        chk("R4 read idle", 32'(acc_cmd), 32'd0);
        chk("R4 read mask", 32'(acc_mask), 32'(model[v]));
    endtask

    task automatic do_lookup(int v, string tag);
        lk_req = 1'b1; lk_vid = VW'(v);
        cyc();
        lk_req = 1'b0;
        chk({tag, " valid"}, 32'(lk_valid), 32'd1);
        chk({tag, " mask"}, 32'(lk_mask), 32'(model[v]));
    endtask

    function automatic logic [NP-1:0] rnd_mask();
        return NP'($urandom);
    endfunction

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic [NP-1:0] old_m;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        rst = 1'b1; idx_we = 0; idx_wvid = '0; acc_we = 0; acc_wcmd = '0;
        acc_wmask = '0; lk_req = 0; lk_vid = '0;
        repeat (4) cyc();
        rst = 1'b0;
        // R1 reset state
        chk("R1 cmd after reset", 32'(acc_cmd), 32'd3);
        chk("R1 mask after reset", 32'(acc_mask), 32'd0);
        chk("R1 idx after reset", 32'(idx_vid), 32'd0);
        n = 0;
        while (acc_cmd == 2'd3 && n < DEPTH + 10) begin n++; cyc(); end
        chk("R1 reset sweep length", 32'(n), 32'(DEPTH));
        chk("R1 R2 idle code", 32'(acc_cmd), 32'd0);
        chk("R9 no request no valid", 32'(lk_valid), 32'd0);
        do_lookup(0, "R1 empty first");
        do_lookup(DEPTH - 1, "R1 empty last");

        // R3 R4 directed, including boundaries
        do_write(5, 10'h2A5);
        do_read(5);
        do_write(0, 10'h3FF);
        do_write(DEPTH - 1, 10'h201);
        do_read(0);
        do_read(DEPTH - 1);
        do_lookup(DEPTH - 1, "R9 last entry");
        do_lookup(4, "R7 neighbour untouched");

        // R7 index rewritten while a write runs
        set_idx(9);
        chk("R7 idx readback", 32'(idx_vid), 32'd9);
        issue(2'd2, 10'h0F0);
        idx_we = 1'b1; idx_wvid = VW'(10);
        cyc();
        idx_we = 1'b0;
        model[9] = 10'h0F0;
        chk("R7 idx changed", 32'(idx_vid), 32'd10);
        do_lookup(9, "R7 old index used");
        do_lookup(10, "R7 new index untouched");

        // R8 idle code only moves the mask field
        issue(2'd0, 10'h155);
        chk("R8 cmd stays idle", 32'(acc_cmd), 32'd0);
        chk("R8 mask field", 32'(acc_mask), 32'h155);
        do_lookup(10, "R8 table unchanged");

        // R6 write attempted during a read
        set_idx(5);
        issue(2'd1, '0);
        issue(2'd2, 10'h3FF);
        chk("R6 cmd still read", 32'(acc_cmd), 32'd1);
        cyc();
        chk("R6 read completes", 32'(acc_cmd), 32'd0);
        chk("R6 mask from table", 32'(acc_mask), 32'(model[5]));
        do_lookup(5, "R6 table unchanged");

        // R10 lookup colliding with host write
        set_idx(20);
        old_m = model[20];
        issue(2'd2, 10'h1C3);
        lk_req = 1'b1; lk_vid = VW'(20);
        cyc();
        lk_req = 1'b0;
        chk("R10 old value on conflict", 32'(lk_mask), 32'(old_m));
        model[20] = 10'h1C3;
        do_lookup(20, "R10 new value later");

        // R5 R11 clear-all with lookup and ignored write during sweep
        set_idx(21);
        issue(2'd3, '0);
        n = 0;
        while (acc_cmd == 2'd3 && n < DEPTH + 10) begin
            lk_req   = (n == 0); lk_vid = VW'(20);
            acc_we   = (n == 5); acc_wcmd = 2'd2; acc_wmask = '1;
            cyc();
            n++;
            if (n == 1) chk("R11 lookup zero in sweep", 32'(lk_mask), 32'd0);
        end
        lk_req = 1'b0; acc_we = 1'b0;
        chk("R5 clear sweep length", 32'(n), 32'(DEPTH));
        chk("R6 mask kept in sweep", 32'(acc_mask), 32'd0);
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        do_lookup(21, "R5 R6 entry cleared");
        do_lookup(0, "R5 first cleared");
        do_read(DEPTH - 1);

        // random traffic
        for (int k = 0; k < 400; k++) begin
            int op;
            int v;
            op = int'($urandom % 3);
            v  = int'($urandom % DEPTH);
            case (op)
                0: do_write(v, rnd_mask());
                1: do_read(v);
                default: do_lookup(v, "R9 random lookup");
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule